// File: doc/BRIEF.md
# Serial Extrinsic Node Unit

This block is the arithmetic core of one node of a belief-propagation decoder for low-density parity-check codes. It works serially: it accepts one edge message per clock and builds a running total. After the final message of a node arrives, it returns one extrinsic result per clock for every edge, in arrival order. Each result combines all messages of the node except the message on its own edge. The block does not add the inputs again for each result. It keeps every message in a FIFO and subtracts each one from the finished total when that edge's result is produced.

Messages are sign-magnitude. The top bit is the sign, and 1 means negative. The lower bits are the magnitude. A build-time role parameter selects one of two variants. In the check role, magnitudes are added and signs are combined by XOR. In the variable role, messages are added as signed numbers, and a channel value, sampled on the closing beat of the node, is included in every result. The next node may stream in while the results of the current node stream out. A pending/active pair of totals and a FIFO of depth 2·DEG make this possible.

Top module: `snu_node`

## Requirements
- R1: A synchronous reset clears the running total, the sign parity, the FIFO and the output stage. A node that is only partly received when reset is applied produces no output.
- R2: In the check role, the magnitude of each output (bits MW-2:0) is the sum of the magnitudes of the other DEG-1 messages of the node.
- R3: In the check role, the sign bit of each output (bit MW-1) is the XOR of the sign bits of the other DEG-1 messages.
- R4: In the variable role, each output is the channel value sampled on the `in_last` beat plus the signed sum of the other DEG-1 messages, written back in sign-magnitude form. A zero result carries sign 0.
- R5: The DEG outputs of a node appear in the same edge order as the inputs. `out_last` is high only on the DEG-th output.
- R6: The first output of a node is valid two clocks after the clock edge that accepts its `in_last` beat. The remaining outputs follow on consecutive clocks.
- R7: A new node may start on the clock right after the previous `in_last`. Its outputs then follow the previous node's outputs with no gap.
- R8: An output magnitude above 2^(MW-1)-1 is clamped to 2^(MW-1)-1. The internal total never wraps, even when every message and the channel value are at full scale.
- R9: Clocks with `in_valid` low between the beats of a node do not change the node's results.
- R10: In the check role, `ch_data` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An edge message is present this clock |
| in_data | input | MW | Edge message, sign-magnitude |
| in_last | input | 1 | Marks the DEG-th message of a node |
| ch_data | input | MW | Channel value, sign-magnitude, sampled with `in_last` (variable role only) |
| out_valid | output | 1 | An extrinsic result is present |
| out_data | output | MW | Extrinsic result, sign-magnitude |
| out_last | output | 1 | Marks the DEG-th result of a node |

## Verification
A check-role and a variable-role instance share the same stimulus. Messages with mixed signs show whether the correct edge is excluded from both the magnitude sum and the sign parity. All-negative full-scale messages exercise the clamp and the wide total. Back-to-back nodes show whether the pending total is handed over without a gap and without corrupting the FIFO. Gapped beats, a reset in the middle of a node, changed channel values in the check role and an all-zero node separate the hold, discard, ignore and zero-sign behaviours.

// File: rtl/snu_pkg.sv
package snu_pkg;
   // Which combining law the node applies
   typedef enum logic {
      ROLE_CHECK = 1'b0,   // magnitude sum, sign parity
      ROLE_VAR   = 1'b1    // signed sum plus channel value
   } node_role_e;
endpackage

// File: rtl/snu_term.sv
// Converts one sign-magnitude message into the signed term the total is built from.
module snu_term #(
   parameter snu_pkg::node_role_e ROLE = snu_pkg::ROLE_CHECK,
   parameter int MW = 8,
   parameter int SW = 12
) (
   input  logic [MW-1:0]        msg,
   output logic signed [SW-1:0] term
);
   localparam int MAGW = MW - 1;

   logic signed [SW-1:0] mag_ext;
   logic                 unused_sign;

   assign mag_ext     = $signed({{(SW-MAGW){1'b0}}, msg[MAGW-1:0]});
   assign unused_sign = msg[MW-1];

   generate
      if (ROLE == snu_pkg::ROLE_VAR) begin : g_signed
         assign term = msg[MW-1] ? -mag_ext : mag_ext;
      end else begin : g_magnitude
         assign term = mag_ext;
      end
   endgenerate
endmodule

// File: rtl/snu_fifo.sv
// Edge-message store: DEPTH entries, any DEPTH, first in first out.
module snu_fifo #(
   parameter int DEPTH = 12,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] PTR_END = PW'(DEPTH - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] fill;

   assign head = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   // R5: edge order relies on the store never losing or inventing entries
   a_r5_fifo_no_overflow : assert property (@(posedge clk) disable iff (rst)
      (push && !pop) |-> (fill != CNT_FULL));
   a_r5_fifo_no_underflow : assert property (@(posedge clk) disable iff (rst)
      pop |-> (fill != '0));
endmodule

// File: rtl/snu_accum.sv
// Builds the node total beat by beat and parks the closed total in the pending bank.
module snu_accum #(
   parameter snu_pkg::node_role_e ROLE = snu_pkg::ROLE_CHECK,
   parameter int MW = 8,
   parameter int SW = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [MW-1:0]        in_data,
   input  logic                 in_last,
   input  logic [MW-1:0]        ch_data,
   input  logic                 take,
   output logic                 pend_vld,
   output logic signed [SW-1:0] pend_total,
   output logic                 pend_par
);
   logic signed [SW-1:0] run_sum;
   logic                 run_par;
   logic signed [SW-1:0] in_term, ch_term, ch_add;

   snu_term #(.ROLE(ROLE), .MW(MW), .SW(SW)) u_in_term (.msg(in_data), .term(in_term));
   snu_term #(.ROLE(ROLE), .MW(MW), .SW(SW)) u_ch_term (.msg(ch_data), .term(ch_term));

   generate
      if (ROLE == snu_pkg::ROLE_VAR) begin : g_with_channel
         assign ch_add = ch_term;
      end else begin : g_no_channel
         assign ch_add = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         run_sum    <= '0;
         run_par    <= 1'b0;
         pend_vld   <= 1'b0;
         pend_total <= '0;
         pend_par   <= 1'b0;
      end else begin
         if (in_valid) begin
            if (in_last) begin
               run_sum    <= '0;
               run_par    <= 1'b0;
               pend_total <= run_sum + in_term + ch_add;
               pend_par   <= run_par ^ in_data[MW-1];
            end else begin
               run_sum <= run_sum + in_term;
               run_par <= run_par ^ in_data[MW-1];
            end
         end
         if (in_valid && in_last) pend_vld <= 1'b1;
         else if (take)           pend_vld <= 1'b0;
      end
   end

   // R7: the pending total must be handed to the output stage before the next node closes
   a_r7_pend_no_overwrite : assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_last && pend_vld) |-> take);
endmodule

// File: rtl/snu_emit.sv
// Active bank and output sequencer: one extrinsic result per clock.
module snu_emit #(
   parameter snu_pkg::node_role_e ROLE = snu_pkg::ROLE_CHECK,
   parameter int DEG = 6,
   parameter int MW  = 8,
   parameter int SW  = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 pend_vld,
   input  logic signed [SW-1:0] pend_total,
   input  logic                 pend_par,
   input  logic [MW-1:0]        head,
   output logic                 take,
   output logic                 pop,
   output logic                 out_valid,
   output logic [MW-1:0]        out_data,
   output logic                 out_last
);
   localparam int MAGW = MW - 1;
   localparam int CW   = $clog2(DEG);
   localparam logic [CW-1:0] LAST_IDX = CW'(DEG - 1);
   localparam logic [SW-1:0] MAG_CAP  = {{(SW-MAGW){1'b0}}, {MAGW{1'b1}}};

   logic                 busy;
   logic [CW-1:0]        idx;
   logic signed [SW-1:0] act_total;
   logic                 act_par;
   logic signed [SW-1:0] own_term, diff;
   logic                 res_neg;
   logic [SW-1:0]        res_abs;
   logic [MAGW-1:0]      res_mag;
   logic                 final_beat;

   snu_term #(.ROLE(ROLE), .MW(MW), .SW(SW)) u_own_term (.msg(head), .term(own_term));

   assign diff       = act_total - own_term;
   assign final_beat = busy && (idx == LAST_IDX);
   assign take       = pend_vld && (!busy || final_beat);
   assign pop        = busy;

   generate
      if (ROLE == snu_pkg::ROLE_VAR) begin : g_var_out
         assign res_neg = diff[SW-1];
         assign res_abs = diff[SW-1] ? $unsigned(-diff) : $unsigned(diff);
      end else begin : g_chk_out
         assign res_neg = act_par ^ head[MW-1];
         assign res_abs = $unsigned(diff);
      end
   endgenerate

   assign res_mag = (res_abs > MAG_CAP) ? {MAGW{1'b1}} : res_abs[MAGW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= 1'b0;
         idx       <= '0;
         act_total <= '0;
         act_par   <= 1'b0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= busy;
         out_last  <= final_beat;
         if (busy) begin
            out_data <= {res_neg, res_mag};
            idx      <= final_beat ? '0 : idx + 1'b1;
         end
         if (take) begin
            busy      <= 1'b1;
            idx       <= '0;
            act_total <= pend_total;
            act_par   <= pend_par;
         end else if (final_beat) begin
            busy <= 1'b0;
         end
      end
   end

   // R5: the closing marker only rides on a valid result
   a_r5_last_has_valid : assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);
   // R6: results inside one node come on consecutive clocks
   a_r6_node_contiguous : assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_last) |=> out_valid);
endmodule

// File: rtl/snu_node.sv
// Serial extrinsic node unit: top level.
module snu_node #(
   parameter snu_pkg::node_role_e ROLE = snu_pkg::ROLE_CHECK,
   parameter int DEG = 6,
   parameter int MW  = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [MW-1:0] in_data,
   input  logic          in_last,
   input  logic [MW-1:0] ch_data,
   output logic          out_valid,
   output logic [MW-1:0] out_data,
   output logic          out_last
);
   // Total holds DEG+1 full-scale terms with sign, so it cannot wrap
   localparam int SW    = (MW - 1) + $clog2(DEG + 1) + 1;
   localparam int DEPTH = 2 * DEG;

   generate
      if (DEG < 2) begin : g_bad_deg
         $error("snu_node: DEG must be 2 or more");
      end
      if (MW < 2) begin : g_bad_mw
         $error("snu_node: MW must be 2 or more");
      end
   endgenerate

   logic                 take, pop, pend_vld, pend_par;
   logic signed [SW-1:0] pend_total;
   logic [MW-1:0]        head;

   snu_accum #(.ROLE(ROLE), .MW(MW), .SW(SW)) u_accum (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .ch_data(ch_data),
      .take(take),
      .pend_vld(pend_vld), .pend_total(pend_total), .pend_par(pend_par)
   );

   snu_fifo #(.DEPTH(DEPTH), .W(MW)) u_fifo (
      .clk(clk), .rst(rst),
      .push(in_valid), .din(in_data),
      .pop(pop), .head(head)
   );

   snu_emit #(.ROLE(ROLE), .DEG(DEG), .MW(MW), .SW(SW)) u_emit (
      .clk(clk), .rst(rst),
      .pend_vld(pend_vld), .pend_total(pend_total), .pend_par(pend_par),
      .head(head),
      .take(take), .pop(pop),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );
endmodule

// File: tb/sim_snu_node.sv
`timescale 1ns/1ps
module sim_snu_node;
   localparam int DEG = 6;
   localparam int MW  = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [MW-1:0] in_data = '0;
   logic          in_last = 1'b0;
   logic [MW-1:0] ch_data = '0;
   logic          o0_valid, o0_last, o1_valid, o1_last;
   logic [MW-1:0] o0_data, o1_data;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   snu_node #(.ROLE(snu_pkg::ROLE_CHECK), .DEG(DEG), .MW(MW)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .ch_data(ch_data), .out_valid(o0_valid), .out_data(o0_data), .out_last(o0_last));
   snu_node #(.ROLE(snu_pkg::ROLE_VAR), .DEG(DEG), .MW(MW)) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .ch_data(ch_data), .out_valid(o1_valid), .out_data(o1_data), .out_last(o1_last));

   // Output capture, sampled away from the active edge
   logic [MW-1:0] c0_d [256];
   logic          c0_l [256];
   int            c0_t [256];
   logic [MW-1:0] c1_d [256];
   logic          c1_l [256];
   int            c1_t [256];
   int n0 = 0;
   int n1 = 0;

   always @(negedge clk) begin
      if (!rst && o0_valid && n0 < 256) begin
         c0_d[n0] = o0_data; c0_l[n0] = o0_last; c0_t[n0] = cyc; n0 = n0 + 1;
      end
      if (!rst && o1_valid && n1 < 256) begin
         c1_d[n1] = o1_data; c1_l[n1] = o1_last; c1_t[n1] = cyc; n1 = n1 + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int smv(input logic [MW-1:0] x);
      return x[MW-1] ? -int'(x[MW-2:0]) : int'(x[MW-2:0]);
   endfunction

   function automatic logic [MW-1:0] ref_chk(input logic [MW-1:0] v[DEG], input int k);
      int  m = 0;
      logic s = 1'b0;
      for (int j = 0; j < DEG; j++) if (j != k) begin
         m += int'(v[j][MW-2:0]);
         s ^= v[j][MW-1];
      end
      if (m > 127) m = 127;
      return {s, 7'(m)};
   endfunction

   function automatic logic [MW-1:0] ref_var(input logic [MW-1:0] v[DEG],
                                             input logic [MW-1:0] ch, input int k);
      int t = smv(ch);
      int a;
      logic s;
      for (int j = 0; j < DEG; j++) if (j != k) t += smv(v[j]);
      s = (t < 0);
      a = s ? -t : t;
      if (a > 127) a = 127;
      return {s, 7'(a)};
   endfunction

   // Drives one node; the caller is at a falling edge. gap = idle clocks between beats.
   task automatic drive_node(input logic [MW-1:0] v[DEG], input logic [MW-1:0] ch,
                             input int gap, output int tl);
      for (int k = 0; k < DEG; k++) begin
         in_valid = 1'b1; in_data = v[k]; in_last = (k == DEG-1); ch_data = ch;
         @(negedge clk);
         if (gap > 0 && k < DEG-1) begin
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
         end
      end
      tl = cyc;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Compares one node at capture bases b0/b1 against the references
   task automatic check_node(input logic [MW-1:0] v[DEG], input logic [MW-1:0] ch,
                             input int tl, input int b0, input int b1, input string tag);
      for (int k = 0; k < DEG; k++) begin
         logic [MW-1:0] e0, e1;
         e0 = ref_chk(v, k);
         e1 = ref_var(v, ch, k);
         chk(b0 + k < n0, {tag, " R5 u0 result present"}, n0, b0 + k + 1);
         chk(b1 + k < n1, {tag, " R5 u1 result present"}, n1, b1 + k + 1);
         if (b0 + k < n0) begin
            chk(c0_d[b0+k][MW-2:0] == e0[MW-2:0], {tag, " R2 check magnitude"},
                int'(c0_d[b0+k][MW-2:0]), int'(e0[MW-2:0]));
            chk(c0_d[b0+k][MW-1] == e0[MW-1], {tag, " R3 check sign"},
                int'(c0_d[b0+k][MW-1]), int'(e0[MW-1]));
            chk(c0_l[b0+k] == (k == DEG-1), {tag, " R5 out_last"},
                int'(c0_l[b0+k]), int'(k == DEG-1));
            chk(c0_t[b0+k] == tl + 2 + k, {tag, " R6 timing"}, c0_t[b0+k], tl + 2 + k);
         end
         if (b1 + k < n1) begin
            chk(c1_d[b1+k] == e1, {tag, " R4 variable result"}, int'(c1_d[b1+k]), int'(e1));
            chk(c1_t[b1+k] == tl + 2 + k, {tag, " R6 variable timing"}, c1_t[b1+k], tl + 2 + k);
         end
      end
   endtask

   task automatic t_reset();
      logic [MW-1:0] v[DEG] = '{8'h05, 8'h10, 8'h83, 8'h22, 8'h01, 8'h90};
      int tl, b0, b1;
      chk(o0_valid == 1'b0 && o1_valid == 1'b0, "R1 idle after reset", int'(o0_valid), 0);
      // partial node, then reset, then a full node
      for (int k = 0; k < 3; k++) begin
         in_valid = 1'b1; in_data = 8'h7F; in_last = 1'b0;
         @(negedge clk);
      end
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      chk(n0 == 0, "R1 partial node produced nothing", n0, 0);
      b0 = n0; b1 = n1;
      drive_node(v, 8'h00, 0, tl);
      idle(DEG + 4);
      chk(n0 - b0 == DEG, "R1 exactly one node out after reset", n0 - b0, DEG);
      check_node(v, 8'h00, tl, b0, b1, "reset");
   endtask

   task automatic t_mixed();
      logic [MW-1:0] v[DEG] = '{8'h0C, 8'h81, 8'h33, 8'hA0, 8'h07, 8'h95};
      int tl, b0 = n0, b1 = n1;
      drive_node(v, 8'h8A, 0, tl);
      idle(DEG + 4);
      check_node(v, 8'h8A, tl, b0, b1, "mixed");
   endtask

   task automatic t_saturate();
      logic [MW-1:0] v[DEG] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      int tl, b0 = n0, b1 = n1;
      drive_node(v, 8'hFF, 0, tl);
      idle(DEG + 4);
      chk(c0_d[b0] == 8'hFF, "R8 check clamp, odd negatives", int'(c0_d[b0]), 255);
      chk(c1_d[b1] == 8'hFF, "R8 variable clamp", int'(c1_d[b1]), 255);
      check_node(v, 8'hFF, tl, b0, b1, "R8 saturate");
   endtask

   task automatic t_back_to_back();
      logic [MW-1:0] va[DEG] = '{8'h01, 8'h02, 8'h03, 8'h84, 8'h05, 8'h06};
      logic [MW-1:0] vb[DEG] = '{8'h40, 8'hC0, 8'h11, 8'h22, 8'h93, 8'h08};
      int ta, tb, b0 = n0, b1 = n1;
      drive_node(va, 8'h10, 0, ta);
      drive_node(vb, 8'h91, 0, tb);
      idle(2 * DEG + 4);
      chk(tb == ta + DEG, "R7 second node started at once", tb, ta + DEG);
      check_node(va, 8'h10, ta, b0, b1, "R7 first");
      check_node(vb, 8'h91, tb, b0 + DEG, b1 + DEG, "R7 second");
   endtask

   task automatic t_gaps();
      logic [MW-1:0] v[DEG] = '{8'h21, 8'h8F, 8'h00, 8'h3C, 8'hB1, 8'h02};
      int tl, b0 = n0, b1 = n1;
      drive_node(v, 8'h05, 2, tl);
      idle(DEG + 4);
      check_node(v, 8'h05, tl, b0, b1, "R9 gaps");
   endtask

   task automatic t_channel_ignored();
      logic [MW-1:0] v[DEG] = '{8'h0A, 8'h0B, 8'h8C, 8'h0D, 8'h0E, 8'h8F};
      int tl, b0 = n0, b1 = n1;
      drive_node(v, 8'h7F, 0, tl);
      idle(DEG + 4);
      for (int k = 0; k < DEG; k++) begin
         logic [MW-1:0] e = ref_chk(v, k);
         chk(c0_d[b0+k] == e, "R10 check role ignores channel", int'(c0_d[b0+k]), int'(e));
      end
      check_node(v, 8'h7F, tl, b0, b1, "R10");
   endtask

   task automatic t_zero();
      logic [MW-1:0] v[DEG] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      int tl, b0 = n0, b1 = n1;
      drive_node(v, 8'h80, 0, tl);
      idle(DEG + 4);
      chk(c1_d[b1] == 8'h00, "R4 zero result has sign 0", int'(c1_d[b1]), 0);
      check_node(v, 8'h80, tl, b0, b1, "zero");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_mixed();
      t_saturate();
      t_back_to_back();
      t_gaps();
      t_channel_ignored();
      t_zero();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule